// File: doc/BRIEF.md
# Word-Packing Serial Packet Transmitter

This block collects 16-bit words that a processor writes to one port address and turns each pair into a 32-bit packet. The lower half carries the sensor sample and the upper half carries the payload attached to it. Once both halves of a packet have been written, the packet is pushed into a small transmit queue. The queue holds completed packets until the serial side is allowed to send them.

A parallel-to-serial stage takes the oldest queued packet when shifting is enabled and the direction input selects transmit. It then drives the packet onto a single output line, one bit per baud tick, framed by a start bit and a stop bit. The processor can read a status word at the same port address to see queue and assembly state. A module enable freezes all state when the block is not in use.

Top module: `pkt_serial_tx`

## Requirements
- R1: After reset `txd` is high, `rd_data` is zero, and the status word equals 16'h0001 (only the empty bit set).
- R2: Strobes take effect only when `blk_en` is high and `port_addr` equals `SFR_ADDR`. A write to any other address changes nothing, and a read from any other address returns zero on `rd_data`.
- R3: A matching write with `sel_lo` high stores `wr_data` as packet bits [15:0] (sensor data). A matching write with `sel_hi` high stores it as bits [31:16] (payload). Status bit 4 shows that a lower half is held and bit 5 that an upper half is held.
- R4: Once both halves are held, status bit 2 (word ready) is high for exactly one cycle. The packet is then pushed into the queue on the next clock edge and both held flags clear.
- R5: A matching read drives the status word on `rd_data` in the same cycle. The layout is: bit 0 queue empty, bit 1 queue full, bit 2 word ready, bit 3 overflow, bit 4 lower held, bit 5 upper held, bit 6 serializer busy, bits [10:8] queue count. All other bits are zero.
- R6: The queue holds `DEPTH` (4) packets and sends them in the order they were pushed. The full bit is set when the count equals `DEPTH`.
- R7: A push into a full queue is dropped, leaving the count unchanged, and it sets the overflow bit. The overflow bit stays set until reset.
- R8: A frame on `txd` has a low start bit, then 32 data bits least significant first, then a high stop bit. The start bit appears on the cycle after the packet is taken. Each following bit appears after one `baud_tick`, and the line is high whenever no frame is in progress.
- R9: While `shift_en` is low, no packet is taken from the queue and `txd` stays high.
- R10: While `dir_rx` is high, no frame starts and a frame already in progress holds its current bit even when baud ticks arrive.
- R11: While `blk_en` is low, writes, reads and baud ticks have no effect. Reads return zero, held halves do not change, and an ongoing frame holds its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_en | input | 1 | Module enable; low freezes all state |
| port_addr | input | 16 | Port address bus |
| wr_data | input | 16 | Write data word |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| sel_lo | input | 1 | Selects the lower (sensor) half for a write |
| sel_hi | input | 1 | Selects the upper (payload) half for a write |
| dir_rx | input | 1 | Direction; low selects transmit |
| shift_en | input | 1 | Allows a queued packet to start shifting |
| baud_tick | input | 1 | One-cycle pulse per serial bit time |
| rd_data | output | 16 | Status word during a matching read, else zero |
| txd | output | 1 | Serial output line, idle high |

## Verification
The bench builds the block with 16-bit halves, a queue depth of 4, a port address of 16'h00A4 and least-significant-first shifting. The depth of 4 means that five packets are enough to reach the full flag, the dropped push and the sticky overflow bit. These five packets then drain as four ordered frames. Baud ticks are driven on every cycle, on every third cycle and by hand. The hand-driven ticks let the bench check the start-bit timing, the direction hold and the enable hold mid-frame bit by bit.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

   // status word bit positions
   localparam int ST_EMPTY   = 0;
   localparam int ST_FULL    = 1;
   localparam int ST_WRDY    = 2;
   localparam int ST_OVF     = 3;
   localparam int ST_HAVE_LO = 4;
   localparam int ST_HAVE_HI = 5;
   localparam int ST_BUSY    = 6;
   localparam int ST_CNT_LSB = 8;

   typedef enum logic {SER_IDLE = 1'b0, SER_SEND = 1'b1} ser_state_e;

endpackage

// File: rtl/pkt_half_buf.sv
module pkt_half_buf #(
   parameter int                ADDR_W   = 16,
   parameter int                DATA_W   = 16,
   parameter logic [ADDR_W-1:0] SFR_ADDR = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [ADDR_W-1:0]   port_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                wr_stb,
   input  logic                sel_lo,
   input  logic                sel_hi,
   output logic                addr_hit,
   output logic                word_rdy,
   output logic                have_lo,
   output logic                have_hi,
   output logic [2*DATA_W-1:0] packet
);

   logic [DATA_W-1:0] lo_q, hi_q;
   logic              wr_go;

   assign addr_hit = (port_addr == SFR_ADDR);
   assign wr_go    = en & wr_stb & addr_hit;
   assign word_rdy = have_lo & have_hi;
   assign packet   = {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_lo <= 1'b0;
         have_hi <= 1'b0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else if (en) begin
         have_lo <= (have_lo & ~word_rdy) | (wr_go & sel_lo);
         have_hi <= (have_hi & ~word_rdy) | (wr_go & sel_hi);
         if (wr_go && sel_lo) lo_q <= wr_data;
         if (wr_go && sel_hi) hi_q <= wr_data;
      end
   end

endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic             full,
   output logic             empty,
   output logic [CNT_W-1:0] cnt
);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rd_ptr];

   function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (do_push && wr_ptr == PTR_W'(i)) mem[i] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= next_ptr(wr_ptr);
         if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/pkt_serializer.sv
module pkt_serializer
   import pkt_tx_pkg::*;
#(
   parameter int PKT_W     = 32,
   parameter bit LSB_FIRST = 1'b1,
   localparam int FRAME = PKT_W + 2,
   localparam int BIT_W = $clog2(FRAME)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             dir_rx,
   input  logic             shift_en,
   input  logic             baud_tick,
   input  logic             fifo_empty,
   input  logic [PKT_W-1:0] fifo_dout,
   output logic             pop,
   output logic             busy,
   output logic             txd
);

   ser_state_e       state;
   logic [FRAME-1:0] sh;
   logic [BIT_W-1:0] idx;
   logic [PKT_W-1:0] ordered;
   logic             go;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign ordered = fifo_dout;
      end else begin : g_msb
         for (genvar i = 0; i < PKT_W; i++) begin : g_rev
            assign ordered[i] = fifo_dout[PKT_W-1-i];
         end
      end
   endgenerate

   assign go   = en & ~dir_rx;
   assign busy = (state == SER_SEND);
   assign pop  = go & ~busy & shift_en & ~fifo_empty;
   assign txd  = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SER_IDLE;
         sh    <= '1;
         idx   <= '0;
      end else if (pop) begin
         state <= SER_SEND;
         sh    <= {1'b1, ordered, 1'b0};
         idx   <= '0;
      end else if (busy && go && baud_tick) begin
         sh <= {1'b1, sh[FRAME-1:1]};
         if (idx == BIT_W'(FRAME - 1)) begin
            state <= SER_IDLE;
            idx   <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pkt_serial_tx.sv
module pkt_serial_tx
   import pkt_tx_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 16,
   parameter logic [ADDR_W-1:0] SFR_ADDR  = 16'h00A4,
   parameter int                DEPTH     = 4,
   parameter bit                LSB_FIRST = 1'b1,
   localparam int PKT_W = 2 * DATA_W,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_en,
   input  logic [ADDR_W-1:0] port_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic              sel_lo,
   input  logic              sel_hi,
   input  logic              dir_rx,
   input  logic              shift_en,
   input  logic              baud_tick,
   output logic [DATA_W-1:0] rd_data,
   output logic              txd
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pkt_serial_tx: DEPTH must be at least 2");
      end
      if (DATA_W < ST_CNT_LSB + CNT_W) begin : g_bad_width
         $error("pkt_serial_tx: DATA_W too narrow for the status word");
      end
   endgenerate

   logic             addr_hit, word_rdy, have_lo, have_hi;
   logic [PKT_W-1:0] packet, fifo_dout;
   logic             push, pop, full, empty, busy, ovf;
   logic [CNT_W-1:0] cnt;
   logic [DATA_W-1:0] status;

   assign push = word_rdy & blk_en;

   pkt_half_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SFR_ADDR(SFR_ADDR)) buf_i (
      .clk(clk), .rst_n(rst_n), .en(blk_en), .port_addr(port_addr),
      .wr_data(wr_data), .wr_stb(wr_stb), .sel_lo(sel_lo), .sel_hi(sel_hi),
      .addr_hit(addr_hit), .word_rdy(word_rdy), .have_lo(have_lo),
      .have_hi(have_hi), .packet(packet)
   );

   pkt_fifo #(.W(PKT_W), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(packet),
      .dout(fifo_dout), .full(full), .empty(empty), .cnt(cnt)
   );

   pkt_serializer #(.PKT_W(PKT_W), .LSB_FIRST(LSB_FIRST)) ser_i (
      .clk(clk), .rst_n(rst_n), .en(blk_en), .dir_rx(dir_rx),
      .shift_en(shift_en), .baud_tick(baud_tick), .fifo_empty(empty),
      .fifo_dout(fifo_dout), .pop(pop), .busy(busy), .txd(txd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ovf <= 1'b0;
      else if (push && full)   ovf <= 1'b1;
   end

   always_comb begin
      status                         = '0;
      status[ST_EMPTY]               = empty;
      status[ST_FULL]                = full;
      status[ST_WRDY]                = word_rdy;
      status[ST_OVF]                 = ovf;
      status[ST_HAVE_LO]             = have_lo;
      status[ST_HAVE_HI]             = have_hi;
      status[ST_BUSY]                = busy;
      status[ST_CNT_LSB +: CNT_W]    = cnt;
   end

   assign rd_data = (blk_en && rd_stb && addr_hit) ? status : '0;

endmodule

// File: rtl/pkt_serial_tx_chk.sv
module pkt_serial_tx_chk #(
   parameter int                ADDR_W   = 16,
   parameter int                DATA_W   = 16,
   parameter logic [ADDR_W-1:0] SFR_ADDR = '0,
   parameter int                DEPTH    = 4,
   parameter int                CNT_W    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              blk_en,
   input logic [ADDR_W-1:0] port_addr,
   input logic              rd_stb,
   input logic              dir_rx,
   input logic              shift_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              txd,
   input logic              busy,
   input logic              push,
   input logic              pop,
   input logic              full,
   input logic              ovf,
   input logic [CNT_W-1:0]  cnt
);

   // R8
   txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   // R6
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   // R7
   full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (cnt == $past(cnt)));

   // R10
   dir_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dir_rx) |=> (txd == $past(txd)));

   // R11
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_en |=> ($stable(cnt) && $stable(txd)));

   // R9
   no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !shift_en) |=> !busy);

   // R2
   miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && port_addr != SFR_ADDR) |-> (rd_data == '0));

endmodule

bind pkt_serial_tx pkt_serial_tx_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SFR_ADDR(SFR_ADDR),
   .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .port_addr(port_addr),
   .rd_stb(rd_stb), .dir_rx(dir_rx), .shift_en(shift_en),
   .rd_data(rd_data), .txd(txd), .busy(busy), .push(push), .pop(pop),
   .full(full), .ovf(ovf), .cnt(cnt)
);

// File: tb/pkt_serial_tx_tb.sv
`timescale 1ns/1ps
module pkt_serial_tx_tb_top;

   localparam logic [15:0] ADDR = 16'h00A4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_en = 1'b1;
   logic [15:0] port_addr = '0;
   logic [15:0] wr_data = '0;
   logic        wr_stb = 1'b0, rd_stb = 1'b0, sel_lo = 1'b0, sel_hi = 1'b0;
   logic        dir_rx = 1'b0, shift_en = 1'b0;
   logic        man_tick = 1'b0, gen_tick = 1'b0, baud_tick;
   int          tick_period = 0;
   int          tcnt = 0;
   logic [15:0] rd_data;
   logic        txd;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   assign baud_tick = (tick_period == 0) ? man_tick : gen_tick;

   always @(negedge clk) begin
      if (tick_period > 0) begin
         if (tcnt >= tick_period - 1) begin tcnt <= 0; gen_tick <= 1'b1; end
         else begin tcnt <= tcnt + 1; gen_tick <= 1'b0; end
      end else begin
         tcnt <= 0; gen_tick <= 1'b0;
      end
   end

   pkt_serial_tx #(.ADDR_W(16), .DATA_W(16), .SFR_ADDR(ADDR), .DEPTH(4),
                   .LSB_FIRST(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .port_addr(port_addr),
      .wr_data(wr_data), .wr_stb(wr_stb), .rd_stb(rd_stb), .sel_lo(sel_lo),
      .sel_hi(sel_hi), .dir_rx(dir_rx), .shift_en(shift_en),
      .baud_tick(baud_tick), .rd_data(rd_data), .txd(txd)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] st(input bit e, f, w, o, l, h, b,
                                      input int c);
      logic [15:0] s = '0;
      s[0] = e; s[1] = f; s[2] = w; s[3] = o; s[4] = l; s[5] = h; s[6] = b;
      s[10:8] = c[2:0];
      return s;
   endfunction

   // called at a negedge; write lands at the next posedge
   task automatic wr_half(input logic [15:0] a, input bit lo,
                          input logic [15:0] d);
      port_addr = a; wr_data = d; wr_stb = 1'b1; sel_lo = lo; sel_hi = !lo;
      @(negedge clk);
      wr_stb = 1'b0; sel_lo = 1'b0; sel_hi = 1'b0; port_addr = '0;
   endtask

   task automatic rd_status(input logic [15:0] a, output logic [15:0] v);
      port_addr = a; rd_stb = 1'b1;
      #1 v = rd_data;
      rd_stb = 1'b0; port_addr = '0;
   endtask

   task automatic put_pkt(input logic [15:0] lo, input logic [15:0] hi);
      wr_half(ADDR, 1'b1, lo);
      wr_half(ADDR, 1'b0, hi);
      @(negedge clk);
   endtask

   task automatic capture(input logic [31:0] exp, input string tag);
      logic [33:0] bits;
      int w = 0;
      while (txd !== 1'b0 && w < 60) begin @(negedge clk); w++; end
      bits[0] = txd;
      for (int b = 1; b < 34; b++) begin
         do @(posedge clk); while (baud_tick !== 1'b1);
         @(negedge clk);
         bits[b] = txd;
      end
      do @(posedge clk); while (baud_tick !== 1'b1);
      @(negedge clk);
      chk(bits[0] == 1'b0, {tag, " start bit"}, bits[0], 0);
      chk(bits[32:1] == exp, {tag, " data lsb first"}, bits[32:1], exp);
      chk(bits[33] == 1'b1, {tag, " stop bit"}, bits[33], 1);
      chk(txd == 1'b1, {tag, " idle after frame"}, txd, 1);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      chk(txd == 1'b1, "R1 txd idle", txd, 1);
      chk(rd_data == 16'h0, "R1 rd_data zero", rd_data, 0);
      rd_status(ADDR, v);
      chk(v == 16'h0001, "R1 status reset", v, 16'h0001);
   endtask

   task automatic t_addr_filter;
      logic [15:0] v;
      wr_half(ADDR + 16'd1, 1'b0, 16'h5555);
      rd_status(ADDR, v);
      chk(v == st(1,0,0,0,0,0,0,0), "R2 mismatched write ignored", v,
          st(1,0,0,0,0,0,0,0));
      rd_status(ADDR ^ 16'h0100, v);
      chk(v == 16'h0, "R2 mismatched read zero", v, 0);
   endtask

   task automatic t_halves;
      logic [15:0] v;
      wr_half(ADDR, 1'b1, 16'h1234);
      rd_status(ADDR, v);
      chk(v == st(1,0,0,0,1,0,0,0), "R3 lower held", v, st(1,0,0,0,1,0,0,0));
      wr_half(ADDR, 1'b0, 16'hBEEF);
      rd_status(ADDR, v);
      chk(v == st(1,0,1,0,1,1,0,0), "R4 word ready", v, st(1,0,1,0,1,1,0,0));
      @(negedge clk);
      rd_status(ADDR, v);
      chk(v == st(0,0,0,0,0,0,0,1), "R5 R4 pushed status", v,
          st(0,0,0,0,0,0,0,1));
      tick_period = 1; shift_en = 1'b1;
      capture(32'hBEEF_1234, "R3 R8 packet halves");
      shift_en = 1'b0;
      rd_status(ADDR, v);
      chk(v == st(1,0,0,0,0,0,0,0), "R5 drained status", v,
          st(1,0,0,0,0,0,0,0));
   endtask

   task automatic t_sparse;
      put_pkt(16'hC3A5, 16'h0F81);
      tick_period = 3; shift_en = 1'b1;
      capture(32'h0F81_C3A5, "R8 sparse ticks");
      shift_en = 1'b0; tick_period = 1;
   endtask

   task automatic t_shift_gate;
      logic [15:0] v;
      bit stayed = 1;
      put_pkt(16'h00FF, 16'hFF00);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) stayed = 0;
      end
      chk(stayed, "R9 line idle without shift_en", stayed, 1);
      rd_status(ADDR, v);
      chk(v == st(0,0,0,0,0,0,0,1), "R9 packet kept", v, st(0,0,0,0,0,0,0,1));
      shift_en = 1'b1;
      capture(32'hFF00_00FF, "R9 released");
      shift_en = 1'b0;
   endtask

   task automatic t_direction;
      logic [15:0] v;
      bit held = 1;
      tick_period = 0; man_tick = 1'b0;
      put_pkt(16'h0003, 16'h8000);
      dir_rx = 1'b1; shift_en = 1'b1;
      repeat (10) @(negedge clk);
      rd_status(ADDR, v);
      chk(txd == 1'b1 && v == st(0,0,0,0,0,0,0,1), "R10 no start in rx",
          {txd, v}, {1'b1, st(0,0,0,0,0,0,0,1)});
      dir_rx = 1'b0;
      @(negedge clk);
      chk(txd == 1'b0, "R8 start bit after take", txd, 0);
      dir_rx = 1'b1; man_tick = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (txd !== 1'b0) held = 0;
      end
      chk(held, "R10 frame held while rx", held, 1);
      dir_rx = 1'b0; man_tick = 1'b0;
      @(negedge clk);
      man_tick = 1'b1;
      @(negedge clk);
      man_tick = 1'b0;
      chk(txd == 1'b1, "R8 first data bit after one tick", txd, 1);
      @(negedge clk);
      chk(txd == 1'b1, "R8 bit holds without tick", txd, 1);
      shift_en = 1'b0; tick_period = 1;
      repeat (40) @(negedge clk);
      rd_status(ADDR, v);
      chk(txd == 1'b1 && v == st(1,0,0,0,0,0,0,0), "R10 frame completes",
          {txd, v}, {1'b1, st(1,0,0,0,0,0,0,0)});
   endtask

   task automatic t_enable;
      logic [15:0] v;
      bit held = 1;
      blk_en = 1'b0;
      wr_half(ADDR, 1'b1, 16'h7777);
      rd_status(ADDR, v);
      chk(v == 16'h0, "R11 read zero while disabled", v, 0);
      blk_en = 1'b1;
      rd_status(ADDR, v);
      chk(v == st(1,0,0,0,0,0,0,0), "R11 write ignored while disabled", v,
          st(1,0,0,0,0,0,0,0));
      tick_period = 0; man_tick = 1'b0;
      put_pkt(16'h0000, 16'h0000);
      shift_en = 1'b1;
      @(negedge clk);
      chk(txd == 1'b0, "R11 frame started", txd, 0);
      blk_en = 1'b0; man_tick = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (txd !== 1'b0) held = 0;
      end
      chk(held, "R11 ticks ignored while disabled", held, 1);
      blk_en = 1'b1; man_tick = 1'b0; shift_en = 1'b0; tick_period = 1;
      repeat (40) @(negedge clk);
      chk(txd == 1'b1, "R11 frame completes after enable", txd, 1);
   endtask

   task automatic t_overflow;
      logic [15:0] v;
      shift_en = 1'b0;
      for (int k = 0; k < 4; k++) put_pkt(16'h0F00 + 16'(k), 16'h00A0 + 16'(k));
      rd_status(ADDR, v);
      chk(v == st(0,1,0,0,0,0,0,4), "R6 full at depth", v, st(0,1,0,0,0,0,0,4));
      put_pkt(16'hDEAD, 16'hDEAD);
      rd_status(ADDR, v);
      chk(v == st(0,1,0,1,0,0,0,4), "R7 dropped push sets overflow", v,
          st(0,1,0,1,0,0,0,4));
      tick_period = 1; shift_en = 1'b1;
      for (int k = 0; k < 4; k++)
         capture({16'h00A0 + 16'(k), 16'h0F00 + 16'(k)}, "R6 queue order");
      shift_en = 1'b0;
      repeat (40) @(negedge clk);
      rd_status(ADDR, v);
      chk(txd == 1'b1 && v == st(1,0,0,1,0,0,0,0),
          "R7 dropped packet not sent and overflow sticky", {txd, v},
          {1'b1, st(1,0,0,1,0,0,0,0)});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr_filter();
      t_halves();
      t_sparse();
      t_shift_gate();
      t_direction();
      t_enable();
      t_overflow();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_chk, n_fail);
         $finish;
      end
   end

endmodule